// File: doc/BRIEF.md
# Status Auto-Polling Engine

The engine keeps reading a short status word from an attached serial device until that word shows the wanted pattern. It asks a command issuer for one status read at a time through a request/done handshake. The issuer returns the received word together with the done pulse. The engine compares the word against a programmable mask and match value, either requiring every selected bit to agree (AND mode) or any one selected bit to agree (OR mode). It then waits a programmable number of clock cycles before asking for the next read.

A match sets a sticky flag that software clears through a dedicated input; the flag also drives an interrupt line when enabled. Depending on configuration the engine either stops on the first match or keeps polling until an abort. An abort given during a read is honoured when that read completes; an abort given during the wait ends polling at once.

Top module: `status_poll_engine`

## Requirements
- R1: After reset `busy`, `rd_req`, `match_flag` and `irq` are all 0.
- R2: A `start` pulse while idle makes `busy` and `rd_req` 1 in the next cycle; `rd_req` then stays 1 until the cycle in which `rd_done` is 1. A `start` while busy has no effect.
- R3: `cfg_size` codes 0,1,2,3 select a 1, 2, 3 or 4 byte status. The received word is right-aligned, so bits [8*(cfg_size+1)-1:0] are compared, and mask and match bits above that range are ignored.
- R4: With `cfg_or_mode`=0 a read matches when every selected bit (mask bit 1, inside the size) of `rd_status` equals its `cfg_match` bit; with no bit selected it always matches.
- R5: With `cfg_or_mode`=1 a read matches when at least one selected bit equals its `cfg_match` bit; with no bit selected it never matches.
- R6: After a read completes without ending polling, `rd_req` is 0 for exactly `cfg_gap` cycles and then 1; with `cfg_gap`=0 it stays 1 into the next cycle.
- R7: With `cfg_auto_stop`=1 a matching read ends polling: `busy` is 0 in the cycle after that `rd_done`, and no further read is requested.
- R8: With `cfg_auto_stop`=0 a matching read does not end polling; reads keep repeating and the flag stays 1 across further matches.
- R9: `match_flag` becomes 1 in the cycle after a matching `rd_done` and stays 1 until a `flag_clr` pulse, which clears it in the next cycle; when a matching `rd_done` and `flag_clr` fall in the same cycle, the flag ends up 1.
- R10: An `abort` during a read ends polling after that read's `rd_done`; an `abort` during the wait makes `busy` 0 in the next cycle with no further read. An abort never sets the flag itself, and an abort while idle has no effect.
- R11: `irq` equals `match_flag` when `irq_en` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mask | input | DATA_W | Bit select for the comparison |
| cfg_match | input | DATA_W | Wanted bit values |
| cfg_size | input | SZ_W | Status size code, bytes minus one |
| cfg_or_mode | input | 1 | 0: AND matching, 1: OR matching |
| cfg_auto_stop | input | 1 | 1: stop polling on the first match |
| cfg_gap | input | GAP_W | Idle cycles between reads |
| irq_en | input | 1 | Interrupt enable for the flag |
| start | input | 1 | Begin polling (pulse) |
| abort | input | 1 | End polling (pulse) |
| flag_clr | input | 1 | Clear the match flag (pulse) |
| rd_req | output | 1 | Status read request to the command issuer |
| rd_done | input | 1 | Read finished, `rd_status` valid |
| rd_status | input | DATA_W | Received status, right-aligned |
| busy | output | 1 | Polling active |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
A matching read completion and a software clear of the flag can land in the same cycle, and so can a read completion and an abort. The bench provokes the first by pulsing the clear every cycle while the engine polls a matching word without stopping, and it provokes the second by timing an abort onto the completing read. A behavioural model predicts each cycle's outputs and is compared on every clock: the flag must stay set when set and clear collide, and busy must drop after a read that completes together with an abort.

// File: rtl/spe_pkg.sv
// Shared types of the status auto-polling engine.
// Assumes: only the engine's own modules import it.
package spe_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_READ = 2'd1,
        PS_GAP  = 2'd2
    } poll_state_t;
endpackage

// File: rtl/spe_match_unit.sv
// Masked comparison of a received status word.
// Bytes above the configured size are removed from the mask, so only the
// right-aligned low bytes take part. AND mode needs all selected bits equal,
// OR mode needs any selected bit equal.
// Assumes: DATA_W is a multiple of 8.
module spe_match_unit #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int SZ_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] want,
    input  logic [SZ_W-1:0]   size_code,
    input  logic              or_mode,
    output logic              hit
);
    logic [DATA_W-1:0] eff_mask;
    logic [DATA_W-1:0] diff;

    // per-byte gating of the mask by the status size
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        logic in_size;
        assign in_size = (int'(size_code) >= g);
        assign eff_mask[g*8 +: 8] = mask[g*8 +: 8] & {8{in_size}};
    end

    assign diff = status ^ want;

    // select the match rule
    always_comb begin
        if (or_mode) hit = |(~diff & eff_mask);
        else         hit = ~|(diff & eff_mask);
    end
endmodule

// File: rtl/spe_gap_timer.sv
// Down-counter that times the wait between two status reads.
// Loaded with the wait length minus one; zero reports the last wait cycle.
// Assumes: load is only raised when the wait is at least one cycle.
module spe_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             zero
);
    logic [GAP_W-1:0] cnt;

    // load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/spe_match_flag.sv
// Sticky match flag with software clear and interrupt gating.
// A set in the same cycle as a clear wins.
// Assumes: set is a single-cycle event from the polling controller.
module spe_match_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // hold the flag until cleared, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: rtl/status_poll_engine.sv
// Status auto-polling engine: requests status reads, compares each result
// under mask and mode, waits cfg_gap cycles between reads, raises a sticky
// flag on a match and stops on a match only when cfg_auto_stop is set.
// Assumes: configuration is stable while busy; rd_done is only given while
// rd_req is high and carries rd_status in the same cycle.
module status_poll_engine #(
    parameter int DATA_W = 32,
    parameter int GAP_W  = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int SZ_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] cfg_match,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic              cfg_or_mode,
    input  logic              cfg_auto_stop,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              irq_en,
    input  logic              start,
    input  logic              abort,
    input  logic              flag_clr,
    output logic              rd_req,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_status,
    output logic              busy,
    output logic              match_flag,
    output logic              irq
);
    import spe_pkg::*;

    poll_state_t state, state_nx;
    logic        abort_pend;
    logic        hit;
    logic        gap_zero;
    logic        read_end;
    logic        timer_load;

    spe_match_unit #(.DATA_W(DATA_W)) u_match (
        .status    (rd_status),
        .mask      (cfg_mask),
        .want      (cfg_match),
        .size_code (cfg_size),
        .or_mode   (cfg_or_mode),
        .hit       (hit)
    );

    spe_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (cfg_gap - 1'b1),
        .zero     (gap_zero)
    );

    assign read_end = (state == PS_READ) && rd_done;

    // next polling state
    always_comb begin
        state_nx = state;
        case (state)
            PS_IDLE: if (start) state_nx = PS_READ;
            PS_READ: begin
                if (rd_done) begin
                    if ((hit && cfg_auto_stop) || abort || abort_pend) state_nx = PS_IDLE;
                    else if (cfg_gap == '0)                            state_nx = PS_READ;
                    else                                               state_nx = PS_GAP;
                end
            end
            PS_GAP: begin
                if (abort)         state_nx = PS_IDLE;
                else if (gap_zero) state_nx = PS_READ;
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    assign timer_load = (state == PS_READ) && (state_nx == PS_GAP);

    // state register and abort request held until the read boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PS_IDLE;
            abort_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == PS_IDLE)                abort_pend <= 1'b0;
            else if ((state == PS_READ) && abort)   abort_pend <= 1'b1;
        end
    end

    assign busy   = (state != PS_IDLE);
    assign rd_req = (state == PS_READ);

    spe_match_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (read_end && hit),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (match_flag),
        .irq    (irq)
    );

    assert_req_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);
    assert_stop_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_done && hit && cfg_auto_stop) |=> !busy);
    assert_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_done && !hit && !abort && !abort_pend && cfg_gap == '0) |=> rd_req);
    assert_abort_in_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_req && abort) |=> !busy);
endmodule

// File: tb/status_poll_engine_test.sv
module status_poll_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_mask = 32'hFF, cfg_match = 32'h0;
    logic [1:0]  cfg_size = 2'd0;
    logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1;
    logic [15:0] cfg_gap = 16'd3;
    logic        irq_en = 1'b1, start = 1'b0, abort = 1'b0, flag_clr = 1'b0;
    logic        rd_done = 1'b0;
    logic [31:0] rd_status = 32'h0;
    logic        rd_req, busy, match_flag, irq;

    int tests = 0, fails = 0, cycles = 0;
    string cur = "R1";
    int dev_lat = 2, dev_cnt = 0;
    logic [31:0] dev_status = 32'h01;

    // behavioural reference state
    bit m_busy = 0, m_req = 0, m_flag = 0, m_abp = 0;
    int m_wait = 0;

    always #2 clk = ~clk;   // 250 MHz

    status_poll_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_match(cfg_match),
        .cfg_size(cfg_size), .cfg_or_mode(cfg_or_mode), .cfg_auto_stop(cfg_auto_stop),
        .cfg_gap(cfg_gap), .irq_en(irq_en), .start(start), .abort(abort),
        .flag_clr(flag_clr), .rd_req(rd_req), .rd_done(rd_done), .rd_status(rd_status),
        .busy(busy), .match_flag(match_flag), .irq(irq));

    function automatic bit ref_hit(logic [31:0] s, logic [31:0] m, logic [31:0] w,
                                   int nb, bit orm);
        int care = 0, same = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < (nb + 1) * 8 && m[i]) begin
                care++;
                if (s[i] == w[i]) same++;
            end
        end
        return orm ? (same > 0) : (same == care);
    endfunction

    task automatic check(string what, logic act, bit exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", cur, what, act, exp, cycles);
        end
    endtask

    // one clock: device response, model update, compare at negedge
    task automatic step();
        bit hit, n_busy, n_req, n_flag, n_abp;
        int n_wait;
        if (rd_req) begin
            if (dev_cnt >= dev_lat) begin rd_done = 1'b1; rd_status = dev_status; dev_cnt = 0; end
            else begin rd_done = 1'b0; dev_cnt++; end
        end else begin
            rd_done = 1'b0; dev_cnt = 0;
        end
        hit = ref_hit(rd_status, cfg_mask, cfg_match, int'(cfg_size), cfg_or_mode);
        n_busy = m_busy; n_req = m_req; n_flag = m_flag; n_abp = m_abp; n_wait = m_wait;
        if (flag_clr) n_flag = 0;
        if (!m_busy) begin
            if (start) begin n_busy = 1; n_req = 1; n_abp = 0; end
        end else if (m_req) begin
            if (abort) n_abp = 1;
            if (rd_done) begin
                if (hit) n_flag = 1;
                if ((hit && cfg_auto_stop) || abort || m_abp) begin
                    n_busy = 0; n_req = 0; n_abp = 0;
                end else if (cfg_gap != 0) begin
                    n_req = 0; n_wait = int'(cfg_gap);
                end
            end
        end else begin
            if (abort) begin n_busy = 0; n_abp = 0; end
            else if (m_wait <= 1) n_req = 1;
            else n_wait = m_wait - 1;
        end
        @(posedge clk);
        m_busy = n_busy; m_req = n_req; m_flag = n_flag; m_abp = n_abp; m_wait = n_wait;
        @(negedge clk);
        cycles++;
        check("busy", busy, m_busy);
        check("rd_req", rd_req, m_req);
        check("match_flag", match_flag, m_flag);
        check("irq", irq, m_flag & irq_en);
        start = 0; abort = 0; flag_clr = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_flag();
        flag_clr = 1; step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        cur = "R1";
        check("busy", busy, 0); check("rd_req", rd_req, 0);
        check("match_flag", match_flag, 0); check("irq", irq, 0);
        run(3);

        // R2, R6: non-matching polling with a gap of 3, start while busy ignored
        cur = "R2"; start = 1; run(5);
        start = 1; run(3);
        cur = "R6"; run(20);
        cur = "R10"; abort = 1; run(10);

        // R10: abort during a read, then abort while idle
        start = 1; step(); step();
        abort = 1; run(8);
        abort = 1; run(3);

        // R4: AND match stops polling (R7)
        cur = "R4"; dev_status = 32'h5A; cfg_match = 32'h5A; start = 1; run(10);
        cur = "R9"; run(2); clear_flag(); run(2);
        cur = "R7"; check("busy", busy, 0);

        // R3: upper bytes ignored for a one-byte status
        cur = "R3"; cfg_size = 2'd0; cfg_mask = 32'hFFFF_FFFF; cfg_match = 32'hABCD_005A;
        dev_status = 32'h0000_005A; start = 1; run(10); clear_flag();
        cfg_size = 2'd1; cfg_mask = 32'h00FF_FFFF; cfg_match = 32'h7712_34FF;
        dev_status = 32'h0000_34FF; start = 1; run(10); clear_flag();
        cfg_size = 2'd3; cfg_match = 32'hAB00_005A; cfg_mask = 32'hFFFF_FFFF;
        dev_status = 32'h0000_005A; start = 1; run(15); abort = 1; run(8);

        // R5: OR mode, one equal bit, no equal bit, empty mask
        cur = "R5"; cfg_size = 2'd0; cfg_or_mode = 1; cfg_mask = 32'h0F; cfg_match = 32'h0F;
        dev_status = 32'h01; start = 1; run(8); clear_flag();
        dev_status = 32'hF0; start = 1; run(15); abort = 1; run(8);
        cfg_mask = 32'h0; start = 1; run(12); abort = 1; run(8);
        cur = "R4"; cfg_or_mode = 0; start = 1; run(8); clear_flag();

        // R8, R9: continuous polling on a match, clear colliding with set
        cur = "R8"; cfg_mask = 32'hFF; cfg_match = 32'h3C; dev_status = 32'h3C;
        cfg_auto_stop = 0; cfg_gap = 16'd2; dev_lat = 1; start = 1; run(12);
        cur = "R9"; for (int i = 0; i < 12; i++) begin flag_clr = 1; step(); end
        run(4);
        cur = "R11"; irq_en = 0; run(3); irq_en = 1; run(2);
        cur = "R10"; abort = 1; run(6); clear_flag();

        // R6: zero gap, back-to-back reads, abort colliding with completion
        cur = "R6"; cfg_gap = 16'd0; dev_status = 32'h00; dev_lat = 1; start = 1; run(12);
        cur = "R10";
        for (int i = 0; i < 4 && !rd_req; i++) step();
        abort = 1; run(6);
        cfg_gap = 16'd1; dev_lat = 0; cur = "R6"; start = 1; run(9); abort = 1; run(5);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule